// File: doc/BRIEF.md
# Double-Buffered Scanline Pixel Composer

This block assembles one raster line of pixels while the previous line is scanned out. It holds two line buffers. The writer fills one of them from a stream of graphics objects. The reader shows the other one, one pixel per advance strobe. An end-of-line strobe swaps the two buffers. The buffer that was just shown is blanked when it is handed back to the writer.

An object is opened with a start strobe. The strobe carries a horizontal start position in coarse units, a 3-bit palette and a decode mode. Graphics bytes then follow, one per valid cycle. Each byte is unpacked into pixel entries at consecutive positions, and the write pointer moves right by the number of coarse positions the byte covers.

Every coarse position holds two fine pixels. The line is therefore scanned out at twice the coarse resolution. A stored entry is a palette and a 2-bit color, and color 0 means background. Objects written later are drawn over earlier ones. A level input makes color-0 pixels opaque, so they paint background instead of being skipped.

Top module: `scanline_composer`

## Requirements
- R1: After reset, both buffers are empty, and every scanned pixel reports background, with palette 0 and color 0 on the outputs.
- R2: Bytes written before an end-of-line strobe are not visible to the reader until that strobe; afterwards the reader shows them, and the writer fills the other buffer.
- R3: A buffer handed back to the writer at a swap is fully blank, so a line with no writes shows only background.
- R4: Mode code 0 (narrow, 2 bits): a byte gives four coarse pixels from bit pairs [7:6],[5:4],[3:2],[1:0], left to right; each pixel has the object palette and that 2-bit color, on both fine pixels of its position.
- R5: Mode code 1 (narrow, 4 bits): a byte gives two coarse pixels from nibbles [7:4] then [3:0]; for nibble v the color is v[1:0] and the palette is {P[2], v[3:2]}.
- R6: Mode code 2 (fine, 1 bit): a byte gives eight fine pixels, bit 7 leftmost; a set bit is color 2 with the object palette.
- R7: Mode code 3 (fine, 2 bits): a byte gives four fine pixels from bit pairs [7:6],[5:4],[3:2],[1:0]; the palette is {P[2],2'b00} and the color is the pair value.
- R8: Mode code 4 (fine, palette in data): bits 7,6 are the two fine pixels of the left position, with palette {P[2],D3,D2}; bits 5,4 are the right position, with palette {P[2],D1,D0}; a set bit is color 2.
- R9: In the narrow modes, with the opaque input low, a color-0 pixel leaves the buffer entry unchanged.
- R10: With the opaque input high, every pixel that would be transparent is written as background, overwriting earlier content.
- R11: In the fine modes with the opaque input low, an off fine pixel is skipped only when its partner in the same coarse position is also off; otherwise it is written as background.
- R12: Where objects overlap, the later written pixel wins.
- R13: Pixels that fall at or beyond the right edge are discarded, the write pointer never wraps, and a start position at or beyond the edge writes nothing.
- R14: After an end-of-line strobe the reader starts at fine pixel 0, moves one fine pixel per advance strobe, and reports background once past the last pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opaque | input | 1 | When high, transparent pixels are written as background |
| obj_start | input | 1 | Opens a new object and loads position, palette and mode |
| obj_hpos | input | HPOS_W | Object start position in coarse units |
| obj_pal | input | 3 | Object palette |
| obj_mode | input | 3 | Decode mode code (0 to 4) |
| byte_valid | input | 1 | A graphics byte is present this cycle |
| byte_data | input | 8 | Graphics byte |
| line_end | input | 1 | End-of-line strobe; swaps the buffers |
| pix_adv | input | 1 | Advances the reader by one fine pixel |
| pix_bg | output | 1 | Current pixel is background or empty |
| pix_pal | output | 3 | Palette of the current pixel (0 when background) |
| pix_col | output | 2 | Color of the current pixel (0 when background) |

## Verification
The bench sweeps every byte value through all five decode modes. Each test object is drawn over a striped underlay and starts at rotating positions, including ones where the object runs off the right edge. A wrong bit order or palette splice would show up as misplaced or miscolored fine pixels. A broken transparency or pairing rule would either erase underlay that should survive or leave underlay showing through where background belongs. A pointer that wraps would leave stray pixels at the left of the line. Further checks show that nothing appears before a swap and that recycled buffers come back blank, which catches a design that swaps late or forgets to clear.

// File: rtl/scomp_pkg.sv
package scomp_pkg;

  localparam int PAL_W  = 3;
  localparam int COL_W  = 2;
  localparam int BYTE_W = 8;
  localparam int SUBS   = 8;   // most fine pixels one byte can produce

  typedef enum logic [2:0] {
    MODE_N2 = 3'd0,  // narrow, 2-bit pixels
    MODE_N4 = 3'd1,  // narrow, 4-bit pixels
    MODE_F1 = 3'd2,  // fine, 1-bit pixels
    MODE_F2 = 3'd3,  // fine, 2-bit pixels
    MODE_FP = 3'd4   // fine, palette carried in data
  } scomp_mode_e;

  typedef struct packed {
    logic [PAL_W-1:0] pal;
    logic [COL_W-1:0] col;   // 0 = background / empty
  } scomp_ent_t;

endpackage

// File: rtl/scomp_decode.sv
module scomp_decode
  import scomp_pkg::*;
(
  input  scomp_mode_e              mode,
  input  logic [PAL_W-1:0]         pal,
  input  logic                     opaque,
  input  logic [BYTE_W-1:0]        data,
  output logic [SUBS-1:0]          sub_we,
  output scomp_ent_t [SUBS-1:0]    sub_ent,
  output logic [2:0]               span
);

  logic [1:0] v2, v2b;
  logic [3:0] v4;
  logic       on_a, on_b;
  logic [1:0] sel;

  always_comb begin
    sub_we  = '0;
    sub_ent = '0;
    span    = 3'd4;
    v2 = '0; v2b = '0; v4 = '0; on_a = 1'b0; on_b = 1'b0; sel = '0;
    unique case (mode)
      MODE_N4: begin
        span = 3'd2;
        for (int i = 0; i < 2; i++) begin
          v4 = data[7-4*i -: 4];
          for (int s = 0; s < 2; s++) begin
            sub_we[2*i+s]      = (v4[1:0] != 2'd0) || opaque;
            sub_ent[2*i+s].pal = {pal[2], v4[3:2]};
            sub_ent[2*i+s].col = v4[1:0];
          end
        end
      end
      MODE_F1: begin
        span = 3'd4;
        for (int i = 0; i < 4; i++) begin
          on_a = data[7-2*i];
          on_b = data[6-2*i];
          sub_we[2*i]        = on_a || on_b || opaque;
          sub_we[2*i+1]      = on_a || on_b || opaque;
          sub_ent[2*i].pal   = pal;
          sub_ent[2*i+1].pal = pal;
          sub_ent[2*i].col   = on_a ? 2'd2 : 2'd0;
          sub_ent[2*i+1].col = on_b ? 2'd2 : 2'd0;
        end
      end
      MODE_F2: begin
        span = 3'd2;
        for (int i = 0; i < 2; i++) begin
          v2  = data[7-4*i -: 2];
          v2b = data[5-4*i -: 2];
          on_a = (v2 != 2'd0);
          on_b = (v2b != 2'd0);
          sub_we[2*i]        = on_a || on_b || opaque;
          sub_we[2*i+1]      = on_a || on_b || opaque;
          sub_ent[2*i].pal   = {pal[2], 2'b00};
          sub_ent[2*i+1].pal = {pal[2], 2'b00};
          sub_ent[2*i].col   = v2;
          sub_ent[2*i+1].col = v2b;
        end
      end
      MODE_FP: begin
        span = 3'd2;
        for (int i = 0; i < 2; i++) begin
          on_a = data[7-2*i];
          on_b = data[6-2*i];
          sel  = (i == 0) ? data[3:2] : data[1:0];
          sub_we[2*i]        = on_a || on_b || opaque;
          sub_we[2*i+1]      = on_a || on_b || opaque;
          sub_ent[2*i].pal   = {pal[2], sel};
          sub_ent[2*i+1].pal = {pal[2], sel};
          sub_ent[2*i].col   = on_a ? 2'd2 : 2'd0;
          sub_ent[2*i+1].col = on_b ? 2'd2 : 2'd0;
        end
      end
      default: begin  // MODE_N2 and unused codes
        span = 3'd4;
        for (int i = 0; i < 4; i++) begin
          v2 = data[7-2*i -: 2];
          for (int s = 0; s < 2; s++) begin
            sub_we[2*i+s]      = (v2 != 2'd0) || opaque;
            sub_ent[2*i+s].pal = pal;
            sub_ent[2*i+s].col = v2;
          end
        end
      end
    endcase
  end

endmodule

// File: rtl/scomp_linebuf.sv
module scomp_linebuf
  import scomp_pkg::*;
#(
  parameter  int NSUB  = 320,
  parameter  int SUB_W = 10,
  localparam int RI_W  = $clog2(NSUB)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   wr_en,
  input  logic [SUB_W-1:0]       wr_base,
  input  logic [SUBS-1:0]        sub_we,
  input  scomp_ent_t [SUBS-1:0]  sub_ent,
  input  logic [RI_W-1:0]        rd_idx,
  output scomp_ent_t             rd_ent
);

  scomp_ent_t       mem_q [NSUB];
  scomp_ent_t       mem_d [NSUB];
  logic [SUB_W:0]   sub_idx [SUBS];

  always_comb begin
    for (int k = 0; k < SUBS; k++)
      sub_idx[k] = {1'b0, wr_base} + (SUB_W+1)'(k);
  end

  always_comb begin
    for (int e = 0; e < NSUB; e++) begin
      mem_d[e] = mem_q[e];
      if (clr) begin
        mem_d[e] = '0;
      end else if (wr_en) begin
        for (int k = 0; k < SUBS; k++)
          if (sub_we[k] && (sub_idx[k] == (SUB_W+1)'(e)))
            mem_d[e] = sub_ent[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < NSUB; e++) mem_q[e] <= '0;
    end else if (clr || wr_en) begin
      for (int e = 0; e < NSUB; e++) mem_q[e] <= mem_d[e];
    end
  end

  assign rd_ent = mem_q[rd_idx];

endmodule

// File: rtl/scanline_composer.sv
module scanline_composer
  import scomp_pkg::*;
#(
  parameter  int POS_COUNT = 160,
  localparam int HPOS_W    = $clog2(POS_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opaque,
  input  logic              obj_start,
  input  logic [HPOS_W-1:0] obj_hpos,
  input  logic [2:0]        obj_pal,
  input  logic [2:0]        obj_mode,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              line_end,
  input  logic              pix_adv,
  output logic              pix_bg,
  output logic [2:0]        pix_pal,
  output logic [1:0]        pix_col
);

  localparam int NSUB  = 2 * POS_COUNT;
  localparam int PTR_W = $clog2(POS_COUNT + 1);
  localparam int SUB_W = PTR_W + 1;
  localparam int RD_W  = $clog2(NSUB + 1);
  localparam int RI_W  = $clog2(NSUB);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      srst_n     <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      srst_n     <= rst_meta_q;
    end
  end

  // writer state
  logic [PTR_W-1:0] wr_ptr_q, wr_ptr_d;
  scomp_mode_e      mode_q, mode_d;
  logic [2:0]       pal_q, pal_d;
  logic             wsel_q, wsel_d;
  logic [RD_W-1:0]  rd_ptr_q, rd_ptr_d;

  logic [SUBS-1:0]        sub_we;
  scomp_ent_t [SUBS-1:0]  sub_ent;
  logic [2:0]             span;
  logic [PTR_W:0]         ptr_sum;

  scomp_decode u_dec (
    .mode   (mode_q),
    .pal    (pal_q),
    .opaque (opaque),
    .data   (byte_data),
    .sub_we (sub_we),
    .sub_ent(sub_ent),
    .span   (span)
  );

  always_comb begin
    ptr_sum  = {1'b0, wr_ptr_q} + (PTR_W+1)'(span);
    wr_ptr_d = wr_ptr_q;
    mode_d   = mode_q;
    pal_d    = pal_q;
    if (obj_start) begin
      mode_d = scomp_mode_e'(obj_mode);
      pal_d  = obj_pal;
      if (PTR_W'(obj_hpos) >= PTR_W'(POS_COUNT)) wr_ptr_d = PTR_W'(POS_COUNT);
      else                                       wr_ptr_d = PTR_W'(obj_hpos);
    end else if (byte_valid) begin
      if (ptr_sum >= (PTR_W+1)'(POS_COUNT)) wr_ptr_d = PTR_W'(POS_COUNT);
      else                                  wr_ptr_d = ptr_sum[PTR_W-1:0];
    end
  end

  always_comb begin
    wsel_d   = line_end ? ~wsel_q : wsel_q;
    rd_ptr_d = rd_ptr_q;
    if (line_end)
      rd_ptr_d = '0;
    else if (pix_adv && (rd_ptr_q < RD_W'(NSUB)))
      rd_ptr_d = rd_ptr_q + RD_W'(1);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      wr_ptr_q <= PTR_W'(POS_COUNT);
      mode_q   <= MODE_N2;
      pal_q    <= '0;
      wsel_q   <= 1'b0;
      rd_ptr_q <= '0;
    end else begin
      if (obj_start || byte_valid) begin
        wr_ptr_q <= wr_ptr_d;
        mode_q   <= mode_d;
        pal_q    <= pal_d;
      end
      if (line_end) wsel_q <= wsel_d;
      if (line_end || pix_adv) rd_ptr_q <= rd_ptr_d;
    end
  end

  // the two buffers
  logic [RI_W-1:0] rd_idx;
  scomp_ent_t      buf_rd [2];

  assign rd_idx = (rd_ptr_q < RD_W'(NSUB)) ? rd_ptr_q[RI_W-1:0] : '0;

  for (genvar g = 0; g < 2; g++) begin : g_buf
    scomp_linebuf #(.NSUB(NSUB), .SUB_W(SUB_W)) u_buf (
      .clk    (clk),
      .rst_n  (srst_n),
      .clr    (line_end && (wsel_q != 1'(g))),
      .wr_en  (byte_valid && !obj_start && (wsel_q == 1'(g))),
      .wr_base({wr_ptr_q, 1'b0}),
      .sub_we (sub_we),
      .sub_ent(sub_ent),
      .rd_idx (rd_idx),
      .rd_ent (buf_rd[g])
    );
  end

  scomp_ent_t disp;
  always_comb begin
    disp    = wsel_q ? buf_rd[0] : buf_rd[1];
    pix_bg  = (rd_ptr_q >= RD_W'(NSUB)) || (disp.col == 2'd0);
    pix_pal = pix_bg ? 3'd0 : disp.pal;
    pix_col = pix_bg ? 2'd0 : disp.col;
  end

endmodule

// File: rtl/scomp_checks.sv
module scomp_checks #(
  parameter  int POS_COUNT = 160,
  localparam int NSUB  = 2 * POS_COUNT,
  localparam int PTR_W = $clog2(POS_COUNT + 1),
  localparam int RD_W  = $clog2(NSUB + 1)
) (
  input logic             clk,
  input logic             srst_n,
  input logic             line_end,
  input logic             pix_adv,
  input logic             wsel,
  input logic [RD_W-1:0]  rd_ptr,
  input logic [PTR_W-1:0] wr_ptr,
  input logic             pix_bg,
  input logic [2:0]       pix_pal,
  input logic [1:0]       pix_col
);

  a_r2_swap: assert property (@(posedge clk) disable iff (!srst_n)
    line_end |=> (wsel != $past(wsel)));

  a_r2_hold: assert property (@(posedge clk) disable iff (!srst_n)
    !line_end |=> (wsel == $past(wsel)));

  a_r14_restart: assert property (@(posedge clk) disable iff (!srst_n)
    line_end |=> (rd_ptr == '0));

  a_r14_step: assert property (@(posedge clk) disable iff (!srst_n)
    (!line_end && pix_adv && (rd_ptr < RD_W'(NSUB))) |=> (rd_ptr == $past(rd_ptr) + RD_W'(1)));

  a_r14_past_end: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_ptr >= RD_W'(NSUB)) |-> pix_bg);

  a_r13_ptr_bound: assert property (@(posedge clk) disable iff (!srst_n)
    wr_ptr <= PTR_W'(POS_COUNT));

  a_r1_bg_clean: assert property (@(posedge clk) disable iff (!srst_n)
    pix_bg |-> ((pix_pal == 3'd0) && (pix_col == 2'd0)));

endmodule

bind scanline_composer scomp_checks #(.POS_COUNT(POS_COUNT)) chk_i (
  .clk     (clk),
  .srst_n  (srst_n),
  .line_end(line_end),
  .pix_adv (pix_adv),
  .wsel    (wsel_q),
  .rd_ptr  (rd_ptr_q),
  .wr_ptr  (wr_ptr_q),
  .pix_bg  (pix_bg),
  .pix_pal (pix_pal),
  .pix_col (pix_col)
);

// File: tb/scanline_composer_tb_top.sv
module scanline_composer_tb_top;

  localparam int POS  = 16;
  localparam int NSUB = 2 * POS;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       opaque, obj_start, byte_valid, line_end, pix_adv;
  logic [3:0] obj_hpos;
  logic [2:0] obj_pal, obj_mode;
  logic [7:0] byte_data;
  logic       pix_bg;
  logic [2:0] pix_pal;
  logic [1:0] pix_col;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  int exp_pal [NSUB];
  int exp_col [NSUB];

  always #5 clk = ~clk;

  scanline_composer #(.POS_COUNT(POS)) dut_i (
    .clk(clk), .rst_n(rst_n), .opaque(opaque),
    .obj_start(obj_start), .obj_hpos(obj_hpos), .obj_pal(obj_pal), .obj_mode(obj_mode),
    .byte_valid(byte_valid), .byte_data(byte_data), .line_end(line_end),
    .pix_adv(pix_adv), .pix_bg(pix_bg), .pix_pal(pix_pal), .pix_col(pix_col)
  );

  // ---------------- reference model ----------------
  task automatic mdl_clear();
    for (int i = 0; i < NSUB; i++) begin exp_pal[i] = 0; exp_col[i] = 0; end
  endtask

  task automatic mdl_put(int pos, int s, int p, int c);
    if (pos < POS) begin exp_pal[2*pos+s] = p; exp_col[2*pos+s] = c; end
  endtask

  task automatic mdl_pair(int pos, bit on0, int p0, int c0, bit on1, int p1, int c1, bit k);
    if (on0) mdl_put(pos, 0, p0, c0); else if (k || on1) mdl_put(pos, 0, 0, 0);
    if (on1) mdl_put(pos, 1, p1, c1); else if (k || on0) mdl_put(pos, 1, 0, 0);
  endtask

  task automatic mdl_byte(int mode, int pal, int ptr, int b, bit k, output int span);
    int v, c, p, v1;
    case (mode)
      1: begin
        span = 2;
        for (int i = 0; i < 2; i++) begin
          v = (b >> (4 - 4*i)) & 15; c = v & 3; p = (pal & 4) | (v >> 2);
          if (c != 0 || k) begin mdl_put(ptr+i, 0, p, c); mdl_put(ptr+i, 1, p, c); end
        end
      end
      2: begin
        span = 4;
        for (int i = 0; i < 4; i++)
          mdl_pair(ptr+i, bit'((b >> (7-2*i)) & 1), pal, 2, bit'((b >> (6-2*i)) & 1), pal, 2, k);
      end
      3: begin
        span = 2;
        for (int i = 0; i < 2; i++) begin
          v = (b >> (6 - 4*i)) & 3; v1 = (b >> (4 - 4*i)) & 3; p = pal & 4;
          mdl_pair(ptr+i, v != 0, p, v, v1 != 0, p, v1, k);
        end
      end
      4: begin
        span = 2;
        for (int i = 0; i < 2; i++) begin
          p = (pal & 4) | ((i == 0) ? ((b >> 2) & 3) : (b & 3));
          mdl_pair(ptr+i, bit'((b >> (7-2*i)) & 1), p, 2, bit'((b >> (6-2*i)) & 1), p, 2, k);
        end
      end
      default: begin
        span = 4;
        for (int i = 0; i < 4; i++) begin
          v = (b >> (6 - 2*i)) & 3;
          if (v != 0 || k) begin mdl_put(ptr+i, 0, pal, v); mdl_put(ptr+i, 1, pal, v); end
        end
      end
    endcase
  endtask

  // ---------------- drivers ----------------
  task automatic start_obj(int hpos, int pal, int mode);
    obj_start = 1'b1; obj_hpos = 4'(hpos); obj_pal = 3'(pal); obj_mode = 3'(mode);
    @(negedge clk);
    obj_start = 1'b0;
  endtask

  task automatic send_byte(int b);
    byte_valid = 1'b1; byte_data = 8'(b);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic swap_lines();
    line_end = 1'b1;
    @(negedge clk);
    line_end = 1'b0;
  endtask

  task automatic check_px(string tag, int idx, logic [5:0] got, logic [5:0] exp);
    tests_run++;
    if (got !== exp) begin
      tests_failed++;
      $display("FAIL %s pixel %0d: got bg=%0b pal=%0d col=%0d, expected bg=%0b pal=%0d col=%0d",
               tag, idx, got[5], got[4:2], got[1:0], exp[5], exp[4:2], exp[1:0]);
    end
  endtask

  // reads a whole line plus one pixel past its end (R14)
  task automatic read_line(string tag);
    logic [5:0] e;
    for (int i = 0; i <= NSUB; i++) begin
      if (i == NSUB || exp_col[i] == 0) e = 6'b100000;
      else e = {1'b0, 3'(exp_pal[i]), 2'(exp_col[i])};
      check_px(tag, i, {pix_bg, pix_pal, pix_col}, e);
      pix_adv = 1'b1;
      @(negedge clk);
    end
    pix_adv = 1'b0;
  endtask

  // underlay: mode 0, palette 5, pixels 3,2,1,0 repeated over the whole line
  task automatic underlay();
    int sp;
    opaque = 1'b0;
    start_obj(0, 5, 0);
    for (int j = 0; j < 4; j++) begin
      send_byte(8'hE4);
      mdl_byte(0, 5, 4*j, 8'hE4, 1'b0, sp);
    end
  endtask

  string mtag [5] = '{"R4", "R5", "R6", "R7", "R8"};

  initial begin
    int sp, ptr, hpos, pal;
    bit k;
    rst_n = 1'b0; opaque = 1'b0; obj_start = 1'b0; byte_valid = 1'b0;
    line_end = 1'b0; pix_adv = 1'b0; obj_hpos = '0; obj_pal = '0; obj_mode = '0;
    byte_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2: after reset the shown line is blank, even while the writer fills the other buffer
    mdl_clear();
    underlay();
    begin
      int keep_pal [NSUB];
      int keep_col [NSUB];
      keep_pal = exp_pal; keep_col = exp_col;
      mdl_clear();
      read_line("R1 R2 before swap");
      exp_pal = keep_pal; exp_col = keep_col;
    end
    swap_lines();
    read_line("R2 R4 after swap");

    // sweep: every byte value in every mode, over an underlay
    for (int mode = 0; mode < 5; mode++) begin
      for (int b = 0; b < 256; b++) begin
        mdl_clear();
        underlay();
        k    = (((b * 7) + mode) % 3) == 0;
        hpos = ((b * 5) + mode) % POS;
        pal  = (b * 3 + mode) % 8;
        opaque = k;
        start_obj(hpos, pal, mode);
        ptr = hpos;
        send_byte(b);
        mdl_byte(mode, pal, ptr, b, k, sp);
        ptr += sp;
        send_byte(b ^ 8'hA5);
        mdl_byte(mode, pal, ptr, b ^ 8'hA5, k, sp);
        opaque = 1'b0;
        swap_lines();
        read_line({mtag[mode], " R9 R10 R11 R12 R13 R14"});
      end
    end

    // R13: start position at the last coarse slot, long object, nothing wraps
    mdl_clear();
    start_obj(POS - 1, 2, 0);
    ptr = POS - 1;
    for (int j = 0; j < 3; j++) begin
      send_byte(8'hFF);
      mdl_byte(0, 2, ptr, 8'hFF, 1'b0, sp);
      ptr += sp;
    end
    swap_lines();
    read_line("R13 edge clip");

    // R3: recycled buffers come back blank
    mdl_clear();
    swap_lines();
    read_line("R3 blank after swap");
    swap_lines();
    read_line("R3 blank after second swap");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: run did not complete, got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

endmodule